// File: doc/BRIEF.md
# Processor Interrupt Pin Controller

This block sits between the asynchronous interrupt and control pins of a processor core and the core's pending-interrupt state. Six pins are defined: external interrupt (index 0), system management (1), machine check (2), checkstop (3), hard reset (4) and soft reset (5). Each pin passes through a synchronizer. The block then compares the pin with a register that holds the last level it accepted for that pin. Only a real change produces an event. The reaction to an event depends on the pin: some pins are level mirrors, machine check reacts to a falling edge only, and two pins drive control outputs.

Four pending bits are kept: bit 0 external, bit 1 system management, bit 2 machine check, bit 3 soft reset. A single request output tells the core that work is waiting. The core clears individual pending bits with one acknowledge strobe per bit. Pin indices at or above 6 are not defined; they have no effect and their level is never recorded.

Top module: `pin_irq_ctrl`

## Requirements
- R1: A pin produces an event only when its synchronized level differs from its recorded level. A pin held at a steady level never sets a pending bit again after that bit has been acknowledged.
- R2: Pin 0 is active high and level sensitive. On a change, pending bit 0 takes the new level.
- R3: Pin 1 is active high and level sensitive. On a change, pending bit 1 takes the new level.
- R4: A high-to-low change of pin 2 sets pending bit 2. A low-to-high change records the level and leaves bit 2 unchanged.
- R5: `halt_o` is high while the recorded level of pin 3 is high, and low otherwise.
- R6: On a change of pin 5, pending bit 3 takes the new level.
- R7: `irq_o` is high when any pending bit is set, and low only when all four are clear.
- R8: Pins at index 6 and above cause no event. Their bits in `level_o` always read 0.
- R9: Recorded levels, pending bits and the outputs derived from them change on the third rising clock edge after a pin changes, and not earlier.
- R10: A high `ack_i[k]` clears pending bit k on the next edge. It is the only way to clear bit 2. If an event sets a bit on the same edge as its acknowledge, the set wins.
- R11: `hreset_o` follows the recorded level of pin 4 and has no other effect inside the block.
- R12: After reset, all pending bits, recorded levels, `irq_o`, `halt_o` and `hreset_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | NUM_IN | Asynchronous pin levels; indices 0..5 defined |
| ack_i | input | 4 | Per-bit clear strobes for the pending bits |
| pend_o | output | 4 | Pending bits: 0 external, 1 system management, 2 machine check, 3 soft reset |
| irq_o | output | 1 | Combined interrupt request |
| halt_o | output | 1 | Halt request from the checkstop pin |
| hreset_o | output | 1 | Hard-reset request |
| level_o | output | NUM_IN | Recorded pin levels |

## Verification
A pin change applied before rising edge e1 passes the two synchronizer flops at e1 and e2. It reaches the recorded level, the pending bits, `irq_o`, `halt_o` and `hreset_o` at e3. An acknowledge takes effect on the single edge that samples it. The bench drives all inputs on falling edges and samples on the falling edge after the edge where a result is due. For the latency check it also samples one falling edge earlier, to show that the old value still holds. The sweeps cover all 256 pin words in binary and in Gray order. The expected values come from a step model written from the requirements. All pending bits are acknowledged at regular points in the sweep.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int unsigned PIN_EXT  = 0;
  localparam int unsigned PIN_SMI  = 1;
  localparam int unsigned PIN_MCK  = 2;
  localparam int unsigned PIN_STOP = 3;
  localparam int unsigned PIN_HRST = 4;
  localparam int unsigned PIN_SRST = 5;
  localparam int unsigned NUM_DEF  = 6;

  localparam int unsigned SRC_EXT  = 0;
  localparam int unsigned SRC_SMI  = 1;
  localparam int unsigned SRC_MCK  = 2;
  localparam int unsigned SRC_SRST = 3;
  localparam int unsigned NUM_SRC  = 4;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0] chain_q [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[b] <= '0;
      else if (STAGES == 1) chain_q[b] <= d_i[b];
      else chain_q[b] <= {chain_q[b][STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[b][STAGES-1];
  end
endmodule

// File: rtl/pin_irq_level_reg.sv
module pin_irq_level_reg
  import pin_irq_pkg::*;
#(
  parameter int unsigned NUM_IN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] smp_i,
  output logic [NUM_IN-1:0] level_o,
  output logic [NUM_IN-1:0] rise_o,
  output logic [NUM_IN-1:0] fall_o
);
  for (genvar i = 0; i < NUM_IN; i++) begin : g_pin
    if (i < NUM_DEF) begin : g_def
      logic lvl_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lvl_q <= 1'b0;
        else lvl_q <= smp_i[i];
      end
      assign level_o[i] = lvl_q;
      assign rise_o[i]  = smp_i[i] & ~lvl_q;
      assign fall_o[i]  = ~smp_i[i] & lvl_q;
    end else begin : g_undef
      // undefined index: never recorded, never an event
      assign level_o[i] = 1'b0;
      assign rise_o[i]  = 1'b0;
      assign fall_o[i]  = 1'b0;
    end
  end
endmodule

// File: rtl/pin_irq_pend.sv
module pin_irq_pend
  import pin_irq_pkg::*;
#(
  parameter int unsigned NUM_IN = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IN-1:0]  rise_i,
  input  logic [NUM_IN-1:0]  fall_i,
  input  logic [NUM_SRC-1:0] ack_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] set_d, clr_d, pend_q;

  always_comb begin
    set_d = '0;
    clr_d = '0;
    set_d[SRC_EXT]  = rise_i[PIN_EXT];
    clr_d[SRC_EXT]  = fall_i[PIN_EXT];
    set_d[SRC_SMI]  = rise_i[PIN_SMI];
    clr_d[SRC_SMI]  = fall_i[PIN_SMI];
    set_d[SRC_MCK]  = fall_i[PIN_MCK];   // falling edge only
    set_d[SRC_SRST] = rise_i[PIN_SRST];
    clr_d[SRC_SRST] = fall_i[PIN_SRST];
  end

  // set beats acknowledge on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else pend_q <= (pend_q & ~clr_d & ~ack_i) | set_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int unsigned NUM_IN      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IN-1:0]  pins_i,
  input  logic [NUM_SRC-1:0] ack_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               irq_o,
  output logic               halt_o,
  output logic               hreset_o,
  output logic [NUM_IN-1:0]  level_o
);
  logic [NUM_IN-1:0] smp, rise, fall, level;

  pin_irq_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pins_i), .q_o(smp)
  );

  pin_irq_level_reg #(.NUM_IN(NUM_IN)) u_lvl (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_i(smp),
    .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  pin_irq_pend #(.NUM_IN(NUM_IN)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .fall_i(fall),
    .ack_i(ack_i), .pend_o(pend_o)
  );

  assign irq_o    = |pend_o;
  assign halt_o   = level[PIN_STOP];
  assign hreset_o = level[PIN_HRST];
  assign level_o  = level;
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk #(
  parameter int unsigned NUM_IN = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        ack_i,
  input logic [3:0]        pend_o,
  input logic              irq_o,
  input logic              halt_o,
  input logic [NUM_IN-1:0] level_o
);
  p_no_spurious_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(level_o) && ($past(ack_i) == 4'b0)) |-> $stable(pend_o));

  p_ext_mirror_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(level_o[0]) |-> (pend_o[0] == level_o[0]));

  p_smi_mirror_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(level_o[1]) |-> (pend_o[1] == level_o[1]));

  p_mck_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(level_o[2]) |-> pend_o[2]);

  p_mck_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(level_o[2]) && !$past(pend_o[2])) |-> !pend_o[2]);

  p_halt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(level_o[3]) |-> halt_o);

  p_srst_mirror_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(level_o[5]) |-> (pend_o[3] == level_o[5]));

  p_irq_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(level_o[0]) || $fell(level_o[2])) |-> irq_o);

  p_mck_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ack_i[2]) && $stable(level_o)) |-> !pend_o[2]);

  if (NUM_IN > 6) begin : g_undef
    p_undef_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      level_o[NUM_IN-1:6] == '0);
  end
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.NUM_IN(NUM_IN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i), .pend_o(pend_o),
  .irq_o(irq_o), .halt_o(halt_o), .level_o(level_o)
);

// File: tb/pin_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pin_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = '0;
  logic [3:0] ack = '0;
  logic [3:0] pend;
  logic       irq, halt, hrst;
  logic [7:0] level;

  int n_chk = 0;
  int n_fail = 0;
  logic [5:0] m_lvl = '0;
  logic [3:0] m_pend = '0;

  always #2 clk = ~clk;

  pin_irq_ctrl #(.NUM_IN(8), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .ack_i(ack),
    .pend_o(pend), .irq_o(irq), .halt_o(halt), .hreset_o(hrst), .level_o(level)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [7:0] v);
    logic [5:0] nl, rs, fl;
    nl = v[5:0];
    rs = nl & ~m_lvl;
    fl = ~nl & m_lvl;
    if (rs[0]) m_pend[0] = 1'b1; else if (fl[0]) m_pend[0] = 1'b0;
    if (rs[1]) m_pend[1] = 1'b1; else if (fl[1]) m_pend[1] = 1'b0;
    if (fl[2]) m_pend[2] = 1'b1;
    if (rs[5]) m_pend[3] = 1'b1; else if (fl[5]) m_pend[3] = 1'b0;
    m_lvl = nl;
  endtask

  task automatic check_all();
    chk("R2", "pend ext", 32'(pend[0]), 32'(m_pend[0]));
    chk("R3", "pend smi", 32'(pend[1]), 32'(m_pend[1]));
    chk("R4", "pend mck", 32'(pend[2]), 32'(m_pend[2]));
    chk("R6", "pend srst", 32'(pend[3]), 32'(m_pend[3]));
    chk("R7", "irq", 32'(irq), 32'(|m_pend));
    chk("R5", "halt", 32'(halt), 32'(m_lvl[3]));
    chk("R11", "hreset", 32'(hrst), 32'(m_lvl[4]));
    chk("R8", "level", 32'(level), 32'({2'b00, m_lvl}));
  endtask

  task automatic step(input logic [7:0] v);
    pins = v;
    repeat (3) @(negedge clk);
    model(v);
    check_all();
  endtask

  task automatic ack_all();
    ack = 4'hF;
    @(negedge clk);
    ack = 4'h0;
    m_pend = '0;
    chk("R10", "pend after ack", 32'(pend), 32'h0);
    chk("R7", "irq drop", 32'(irq), 32'h0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", "pend reset", 32'(pend), 32'h0);
    chk("R12", "outs reset", 32'({irq, halt, hrst}), 32'h0);
    chk("R12", "level reset", 32'(level), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: latency of exactly three edges
    pins = 8'h01;
    repeat (2) @(negedge clk);
    chk("R9", "level early", 32'(level), 32'h0);
    chk("R9", "pend early", 32'(pend), 32'h0);
    @(negedge clk);
    model(8'h01);
    chk("R9", "level due", 32'(level), 32'h1);
    chk("R9", "pend due", 32'(pend), 32'h1);

    // R1: acknowledged bit stays clear while pin holds high
    ack = 4'h1;
    @(negedge clk);
    ack = 4'h0;
    m_pend[0] = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1", "no re-event", 32'(pend[0]), 32'h0);

    // R4: rise of mck is silent, fall latches, only ack clears
    step(8'h05);
    chk("R4", "mck rise", 32'(pend[2]), 32'h0);
    step(8'h01);
    chk("R4", "mck fall", 32'(pend[2]), 32'h1);
    step(8'h00);
    chk("R10", "mck held", 32'(pend[2]), 32'h1);
    ack = 4'h4;
    @(negedge clk);
    ack = 4'h0;
    m_pend[2] = 1'b0;
    chk("R10", "mck ack", 32'(pend[2]), 32'h0);

    // R10: event on the same edge as ack wins
    pins = 8'h01;
    repeat (2) @(negedge clk);
    ack = 4'h1;
    @(negedge clk);
    ack = 4'h0;
    model(8'h01);
    chk("R10", "set beats ack", 32'(pend[0]), 32'h1);

    // R8: undefined pins alone do nothing
    step(8'hC1);
    chk("R8", "undef ignored", 32'(pend), 32'(m_pend));

    // binary and Gray sweeps over all pin words
    for (int v = 0; v < 256; v++) begin
      step(8'(v));
      if (v % 32 == 31) ack_all();
    end
    for (int v = 0; v < 256; v++) begin
      step(8'(v ^ (v >> 1)));
      if (v % 32 == 31) ack_all();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule